// File: doc/BRIEF.md
# CAN Receive Message Queue

This block is a three-entry receive queue that sits between a CAN receive engine and the processor. Each entry holds one complete received frame: a 29-bit identifier, an extended-format bit, a remote-request bit, a 4-bit length code and eight data bytes, all packed into one 99-bit word. The engine presents a frame with a one-cycle store strobe. Software reads the oldest frame at the output and frees that entry with a one-cycle release strobe.

The block keeps a write slot, a read slot and a pending-frame level, and raises full and valid indications. If a frame arrives while all three entries are occupied, it replaces the most recently stored frame and sets a sticky overrun flag. A store and a release may arrive in the same cycle at any level. In that case the slots and the level are updated together, so the output always shows the oldest frame that has not been released.

Top module: `can_rxq_fifo`

## Requirements
- R1: The queue holds at most three frames. `level` reports 0 to 3, and `full` is high exactly while `level` is 3.
- R2: A store (`wr_en` high) with `level` below 3 and no release writes `wr_msg` into the queue and raises `level` by one in the next cycle.
- R3: After any sequence of stores and releases, `rd_msg` shows the oldest unreleased frame whenever `level` is nonzero.
- R4: A release (`rel` high) with `level` nonzero and no store removes the oldest frame and lowers `level` by one in the next cycle.
- R5: A store with `level` at 3 and no release replaces the newest stored frame and keeps `level` at 3. The two older frames stay in order.
- R6: A store and a release in the same cycle with `level` at 1 or 2 remove the oldest frame, append the new one and leave `level` unchanged.
- R7: A store and a release in the same cycle with `level` at 0 store the frame and ignore the release, giving `level` 1. With `level` at 3 they release the oldest frame, append the new one and do not set overrun.
- R8: `overrun` is set by every overwrite on full and stays set until a cycle with `ovr_clr` high. If an overwrite and a clear fall in the same cycle, the overwrite wins.
- R9: A release with `level` at 0 and no store is ignored: `level`, `rd_valid` and `overrun` keep their values.
- R10: `rd_valid` is high exactly while `level` is nonzero.
- R11: A synchronous reset (`rst` high at a clock edge) empties the queue and clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Store strobe from the receive engine |
| wr_msg | input | 99 | Frame to store: {id[28:0], ide, rtr, dlc[3:0], data[63:0]} |
| rel | input | 1 | Release strobe from software |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rd_msg | output | 99 | Oldest pending frame |
| rd_valid | output | 1 | At least one frame pending |
| level | output | 2 | Number of pending frames |
| full | output | 1 | Three frames pending |
| overrun | output | 1 | Sticky flag for an overwrite on full |

## Verification
A read slot that drifts from the write slot and the level shows up at `rd_msg` in the cycle after the faulty update. From then on the output shows a frame that was already released or overwritten, while `level` still looks correct. The bench therefore compares the head frame against a reference queue after every cycle. It does this at all four levels and for every store, release and overwrite combination, so a slot error is found one cycle after it is made and not when the queue next drains.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;
  localparam int SLOTS = 3;
  localparam int PTR_W = 2;
  localparam int LVL_W = 2;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_POP,
    OP_SWAP,
    OP_OVERWRITE
  } rxq_op_e;

  function automatic logic [PTR_W-1:0] slot_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SLOTS - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] slot_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(SLOTS - 1) : p - PTR_W'(1);
  endfunction

  function automatic rxq_op_e decode_op(input logic [LVL_W-1:0] lvl,
                                        input logic wr, input logic rl);
    rxq_op_e op;
    if (wr && rl)      op = (lvl == '0) ? OP_PUSH : OP_SWAP;
    else if (wr)       op = (lvl == LVL_W'(SLOTS)) ? OP_OVERWRITE : OP_PUSH;
    else if (rl)       op = (lvl == '0) ? OP_IDLE : OP_POP;
    else               op = OP_IDLE;
    return op;
  endfunction
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import can_rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rel,
  input  logic             ovr_clr,
  output logic [PTR_W-1:0] wr_slot,
  output logic [PTR_W-1:0] rd_slot,
  output logic [LVL_W-1:0] level,
  output logic             overrun,
  output logic             do_write,
  output logic             do_overwrite
);
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [LVL_W-1:0] lvl_q;
  logic             ovr_q;
  rxq_op_e          op;

  always_comb begin
    op           = decode_op(lvl_q, wr_en, rel);
    do_overwrite = (op == OP_OVERWRITE);
    do_write     = (op == OP_PUSH) || (op == OP_SWAP) || do_overwrite;
    // an overwrite lands on the newest entry, one behind the write slot
    wr_slot      = do_overwrite ? slot_dec(wp_q) : wp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      unique case (op)
        OP_PUSH: begin
          wp_q  <= slot_inc(wp_q);
          lvl_q <= lvl_q + LVL_W'(1);
        end
        OP_POP: begin
          rp_q  <= slot_inc(rp_q);
          lvl_q <= lvl_q - LVL_W'(1);
        end
        OP_SWAP: begin
          wp_q <= slot_inc(wp_q);
          rp_q <= slot_inc(rp_q);
        end
        default: ;
      endcase
      if (do_overwrite)  ovr_q <= 1'b1;
      else if (ovr_clr)  ovr_q <= 1'b0;
    end
  end

  assign rd_slot = rp_q;
  assign level   = lvl_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import can_rxq_pkg::*;
#(
  parameter int MSG_W = 99
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] wr_slot,
  input  logic [MSG_W-1:0] wr_msg,
  input  logic [PTR_W-1:0] rd_slot,
  output logic [MSG_W-1:0] rd_msg
);
  logic [MSG_W-1:0] slot_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (wr_slot == PTR_W'(g))) slot_q[g] <= wr_msg;
    end
  end

  always_comb begin
    rd_msg = slot_q[0];
    for (int i = 1; i < SLOTS; i++) begin
      if (rd_slot == PTR_W'(i)) rd_msg = slot_q[i];
    end
  end
endmodule

// File: rtl/can_rxq_fifo.sv
module can_rxq_fifo
  import can_rxq_pkg::*;
#(
  parameter int ID_W   = 29,
  parameter int DLC_W  = 4,
  parameter int DATA_B = 8,
  localparam int MSG_W = ID_W + 2 + DLC_W + 8 * DATA_B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [MSG_W-1:0] wr_msg,
  input  logic             rel,
  input  logic             ovr_clr,
  output logic [MSG_W-1:0] rd_msg,
  output logic             rd_valid,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             overrun
);
  logic [PTR_W-1:0] wr_slot, rd_slot;
  logic             do_write, do_overwrite;

  rxq_ctrl u_ctrl (
    .clk, .rst, .wr_en, .rel, .ovr_clr,
    .wr_slot, .rd_slot, .level, .overrun, .do_write, .do_overwrite
  );

  rxq_store #(.MSG_W(MSG_W)) u_store (
    .clk, .we(do_write), .wr_slot, .wr_msg, .rd_slot, .rd_msg
  );

  assign rd_valid = (level != '0);
  assign full     = (level == LVL_W'(SLOTS));
endmodule

// File: rtl/can_rxq_fifo_chk.sv
module can_rxq_fifo_chk #(
  parameter int MSG_W = 99
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rel,
  input logic             ovr_clr,
  input logic [MSG_W-1:0] rd_msg,
  input logic             rd_valid,
  input logic [1:0]       level,
  input logic             full,
  input logic             overrun,
  input logic             do_overwrite
);
  assert_full_valid_R1: assert property (@(posedge clk) disable iff (rst)
    full |-> rd_valid);

  assert_store_grows_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rel && level != 2'd3) |=> level == $past(level) + 2'd1);

  assert_release_shrinks_R4: assert property (@(posedge clk) disable iff (rst)
    (rel && !wr_en && level != 2'd0) |=> level == $past(level) - 2'd1);

  assert_overwrite_keeps_full_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rel && level == 2'd3) |=> (level == 2'd3) && overrun);

  assert_swap_level_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rel && (level == 2'd1 || level == 2'd2)) |=> level == $past(level));

  assert_swap_full_no_ovr_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rel && level == 2'd3) |-> !do_overwrite);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun);

  assert_overwrite_sets_R8: assert property (@(posedge clk) disable iff (rst)
    do_overwrite |=> overrun);

  assert_empty_release_R9: assert property (@(posedge clk) disable iff (rst)
    (rel && !wr_en && level == 2'd0) |=> (level == 2'd0) && !rd_valid);

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (level == 2'd0) && !overrun);
endmodule

bind can_rxq_fifo can_rxq_fifo_chk #(.MSG_W(MSG_W)) u_chk (
  .clk, .rst, .wr_en, .rel, .ovr_clr, .rd_msg, .rd_valid,
  .level, .full, .overrun, .do_overwrite
);

// File: tb/can_rxq_fifo_bench.sv
module can_rxq_fifo_bench;
  localparam int MW = 99;

  typedef struct {
    string           tag;
    int              lvl;
    logic            ovr;
    logic [MW-1:0]   head;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst, wr_en, rel, ovr_clr;
  logic [MW-1:0] wr_msg, rd_msg;
  logic          rd_valid, full, overrun;
  logic [1:0]    level;

  int errors = 0;
  int checks = 0;

  logic [MW-1:0] mq[$];
  logic          movr;
  exp_t          exp_q[$];

  always #4 clk = ~clk;

  can_rxq_fifo u_can_rxq_fifo (
    .clk, .rst, .wr_en, .wr_msg, .rel, .ovr_clr,
    .rd_msg, .rd_valid, .level, .full, .overrun
  );

  function automatic logic [MW-1:0] mk(input int n);
    logic [MW-1:0] m;
    m = '0;
    for (int b = 0; b < 12; b++) m[b*8 +: 8] = 8'(n * 37 + b * 11 + 5);
    m[MW-1 -: 8] = 8'(n);
    return m;
  endfunction

  task automatic chk(input string tag, input logic ok, input logic [MW-1:0] act,
                     input logic [MW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, update the reference, queue the expectation
  task automatic step(input string tag, input logic r, input logic w,
                      input int n, input logic l, input logic c);
    exp_t e;
    @(posedge clk);
    #2;
    rst = r; wr_en = w; wr_msg = mk(n); rel = l; ovr_clr = c;
    if (r) begin
      mq.delete(); movr = 1'b0;
    end else begin
      if (w && l && mq.size() == 0) mq.push_back(mk(n));
      else if (w && l) begin void'(mq.pop_front()); mq.push_back(mk(n)); end
      else if (w && mq.size() == 3) begin mq[2] = mk(n); movr = 1'b1; end
      else if (w) mq.push_back(mk(n));
      else if (l && mq.size() != 0) void'(mq.pop_front());
      if (w && !l && mq.size() == 3 && movr) ; // overwrite already recorded
      else if (c) movr = 1'b0;
    end
    e.tag = tag; e.lvl = mq.size(); e.ovr = movr;
    e.head = (mq.size() != 0) ? mq[0] : '0;
    exp_q.push_back(e);
  endtask

  // monitor: pop each expectation at the edge that applies it, compare mid-cycle
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        #4;
        chk({e.tag, " level"}, level == 2'(e.lvl), MW'(level), MW'(e.lvl));
        chk("R10 valid", rd_valid == (e.lvl != 0), MW'(rd_valid), MW'(e.lvl != 0));
        chk("R1 full", full == (e.lvl == 3), MW'(full), MW'(e.lvl == 3));
        chk({e.tag, " R8 overrun"}, overrun == e.ovr, MW'(overrun), MW'(e.ovr));
        if (e.lvl != 0) chk({e.tag, " R3 head"}, rd_msg == e.head, rd_msg, e.head);
      end
    end
  end

  initial begin
    for (int cyc = 0; cyc < 5000; cyc++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    movr = 1'b0;
    rst = 1'b1; wr_en = 1'b0; rel = 1'b0; ovr_clr = 1'b0; wr_msg = '0;
    step("R11 reset", 1, 0, 0, 0, 0);
    step("R2 store A", 0, 1, 1, 0, 0);
    step("R2 store B", 0, 1, 2, 0, 0);
    step("R2 store C", 0, 1, 3, 0, 0);
    step("R5 overwrite D", 0, 1, 4, 0, 0);
    step("R5 overwrite E", 0, 1, 5, 0, 0);
    step("R4 release", 0, 0, 0, 1, 0);
    step("R6 swap at 2", 0, 1, 6, 1, 0);
    step("R4 release", 0, 0, 0, 1, 0);
    step("R6 swap at 1", 0, 1, 7, 1, 0);
    step("R2 store", 0, 1, 8, 0, 0);
    step("R2 store", 0, 1, 9, 0, 0);
    step("R7 swap at 3", 0, 1, 10, 1, 0);
    step("R7 swap at 3", 0, 1, 11, 1, 0);
    step("R8 clear", 0, 0, 0, 0, 1);
    step("R5 overwrite", 0, 1, 12, 0, 0);
    step("R8 set beats clear", 0, 1, 13, 0, 1);
    step("R8 held", 0, 0, 0, 0, 0);
    step("R4 release", 0, 0, 0, 1, 0);
    step("R4 release", 0, 0, 0, 1, 0);
    step("R4 release", 0, 0, 0, 1, 0);
    step("R9 empty release", 0, 0, 0, 1, 0);
    step("R7 swap at 0", 0, 1, 14, 1, 0);
    step("R6 swap at 1", 0, 1, 15, 1, 0);
    step("R2 store", 0, 1, 16, 0, 0);
    step("R6 swap at 2", 0, 1, 17, 1, 0);
    step("R6 swap at 2", 0, 1, 18, 1, 0);
    step("R6 swap at 2", 0, 1, 19, 1, 0);
    step("R2 store", 0, 1, 20, 0, 0);
    step("R11 reset", 1, 1, 21, 0, 0);
    step("R9 empty release", 0, 0, 0, 1, 0);
    step("R2 store", 0, 1, 22, 0, 0);
    for (int k = 0; k < 12; k++)
      step("R3 mixed", 0, (k % 3) != 1, 30 + k, (k % 2) == 0, 0);
    step("idle", 0, 0, 0, 0, 0);
    @(posedge clk);
    @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule